// File: doc/BRIEF.md
# Sparse Template Rule Decoder

This block converts a vector of per-channel spike counts into a vector of binary state scores, one bit per decodable state. Each state owns a short, fixed-size list of rules. A rule names one input channel and a minimum count. The state's bit is set only when every rule in its list is met. Because each template keeps only a few channel/threshold pairs rather than a full per-channel vector, rule storage stays small and the block needs only comparisons, with no arithmetic.

When a count vector is strobed in, the block latches it and walks the rule memory one entry per clock, state by state. It folds each state's comparison results into a single bit and gathers the bits into the score vector. The score appears with a one-cycle valid pulse once every state has been evaluated. Rules are loaded through a simple write port while the block is idle. A strobe that arrives during a pass is reported as an overrun and is discarded.

Top module: `sparse_rule_decoder`

## Requirements
- R1: A rule is met when the unsigned count of its channel is greater than or equal to its threshold. Channel c occupies bits `cnt_vec[CNT_W*c +: CNT_W]`. The threshold is a 3-bit value from 1 to 7.
- R2: The rule entry for state s, slot k is at address s*RULES_PER_STATE+k. It holds a valid flag in the top bit, the channel pointer in the next PTR_W bits and the threshold in the low 3 bits. A state's bit is 1 only when all of its valid rules are met.
- R3: An entry whose valid flag is 0 counts as met, so an empty slot never stops a state from firing. A state whose entries are all invalid scores 0.
- R4: Bit i of `score` is the result for state i.
- R5: `score_valid` is high for exactly one cycle. It rises NUM_STATES*RULES_PER_STATE cycles after the clock edge that accepts a strobe. `busy` is high from the cycle after acceptance until the cycle in which `score_valid` is high, and it is low in that cycle.
- R6: A strobe seen while `busy` is high raises `overrun` for one cycle. The pass in progress completes using the counts it latched, and the dropped strobe produces no score.
- R7: A rule write while `busy` is high is ignored. A write while idle is used from the next pass on.
- R8: After reset, every rule entry is invalid and `score`, `score_valid`, `busy` and `overrun` are 0.
- R9: `score` holds its value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_valid | input | 1 | Strobe: a new count vector is on `cnt_vec` |
| cnt_vec | input | NUM_CH*CNT_W | Packed per-channel spike counts |
| rule_wr_en | input | 1 | Rule memory write enable |
| rule_wr_addr | input | ADDR_W | Rule entry address (state*RULES_PER_STATE+slot) |
| rule_wr_data | input | 1+PTR_W+3 | Rule entry {valid, channel pointer, threshold} |
| busy | output | 1 | A decode pass is in progress |
| overrun | output | 1 | One-cycle flag: a strobe was dropped |
| score_valid | output | 1 | One-cycle pulse marking a fresh score |
| score | output | NUM_STATES | State score vector, bit i = state i |

## Verification
A wrong slot or state index inside the sequencer shows up on the first pass after it goes wrong. Either the valid pulse arrives at a latency other than NUM_STATES*RULES_PER_STATE cycles, or a rule's result lands in a neighbouring score bit. A stale or corrupted count latch, or a write that slips past the busy lock, produces a wrong score on the very next valid pulse. Every such fault is therefore visible at the ports within one pass of at most NUM_STATES*RULES_PER_STATE+1 cycles. The sweeps pair every threshold with every count value, and they pair the overrun strobe and the locked-out write with a pass whose result would change if either one leaked through.

// File: rtl/sd_pkg.sv
// Shared definitions for the sparse template rule decoder.
// Assumes threshold fields are 3 bits wide (counts 1..7 per window).
package sd_pkg;

    localparam int unsigned THR_W = 3;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_phase_e;

    // Index width for a count of n items, never below one bit.
    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sd_rule_mem.sv
// Rule storage: one register per rule entry, written through a single
// port and read combinationally at the sequencer's address.
// Assumes the caller raises wr_lock for the whole of a decode pass.
// Writes to addresses past NUM_RULES-1 fall on no entry and are lost.
module sd_rule_mem #(
    parameter int unsigned NUM_RULES = 16,
    parameter int unsigned ENTRY_W   = 9,
    parameter int unsigned ADDR_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_lock,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);

    logic [ENTRY_W-1:0] entry_q [NUM_RULES];

    for (genvar e = 0; e < NUM_RULES; e++) begin : g_entry
        // Clear to invalid on reset; accept a write only when unlocked.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[e] <= '0;
            end else if (wr_en && !wr_lock && (wr_addr == ADDR_W'(e))) begin
                entry_q[e] <= wr_data;
            end
        end
    end

    // Present the entry the sequencer points at.
    always_comb begin
        rd_data = entry_q[rd_addr];
    end

endmodule

// File: rtl/sd_sequencer.sv
// Pass sequencer: accepts a strobe when idle, then steps through every
// rule slot of every state, one entry per cycle, in ascending order.
// Flags a strobe that arrives mid-pass as an overrun and drops it.
module sd_sequencer
    import sd_pkg::*;
#(
    parameter int unsigned NUM_STATES      = 8,
    parameter int unsigned RULES_PER_STATE = 2,
    parameter int unsigned STATE_W         = 3,
    parameter int unsigned SLOT_W          = 1,
    parameter int unsigned ADDR_W          = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    output logic              accept,
    output logic              busy,
    output logic              overrun,
    output logic              slot_last,
    output logic              state_last,
    output logic [ADDR_W-1:0] rule_addr
);

    seq_phase_e         phase_q;
    logic [STATE_W-1:0] state_q;
    logic [SLOT_W-1:0]  slot_q;
    logic               overrun_q;

    // Decode position and handshake from the current phase.
    always_comb begin
        busy       = (phase_q == SEQ_RUN);
        accept     = start_req && (phase_q == SEQ_IDLE);
        slot_last  = (slot_q == SLOT_W'(RULES_PER_STATE - 1));
        state_last = (state_q == STATE_W'(NUM_STATES - 1));
        rule_addr  = ADDR_W'(state_q) * ADDR_W'(RULES_PER_STATE) + ADDR_W'(slot_q);
        overrun    = overrun_q;
    end

    // Advance through slots and states; return to idle after the last rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= SEQ_IDLE;
            state_q <= '0;
            slot_q  <= '0;
        end else begin
            case (phase_q)
                SEQ_IDLE: begin
                    if (start_req) begin
                        phase_q <= SEQ_RUN;
                        state_q <= '0;
                        slot_q  <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (slot_last) begin
                        slot_q <= '0;
                        if (state_last) begin
                            phase_q <= SEQ_IDLE;
                            state_q <= '0;
                        end else begin
                            state_q <= state_q + STATE_W'(1);
                        end
                    end else begin
                        slot_q <= slot_q + SLOT_W'(1);
                    end
                end
                default: phase_q <= SEQ_IDLE;
            endcase
        end
    end

    // Register a one-cycle overrun flag for strobes seen mid-pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun_q <= 1'b0;
        end else begin
            overrun_q <= start_req && (phase_q == SEQ_RUN);
        end
    end

endmodule

// File: rtl/sd_rule_eval.sv
// Rule evaluator: holds the latched count vector, compares the pointed-to
// count with the entry's threshold, and folds the per-slot results of one
// state through a shift register into a single state bit.
// Assumes CNT_W >= 1; pointers past NUM_CH-1 read a count of zero.
// state_bit is meaningful in the cycle of a state's last slot.
module sd_rule_eval
    import sd_pkg::*;
#(
    parameter int unsigned NUM_CH          = 32,
    parameter int unsigned CNT_W           = 4,
    parameter int unsigned RULES_PER_STATE = 2,
    parameter int unsigned PTR_W           = 5,
    parameter int unsigned ENTRY_W         = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [NUM_CH*CNT_W-1:0] cnt_in,
    input  logic                    step,
    input  logic [ENTRY_W-1:0]      rule,
    output logic                    state_bit
);

    localparam int unsigned CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

    logic [NUM_CH*CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0]        cnt_arr [NUM_CH];
    logic                    ent_valid;
    logic [PTR_W-1:0]        ent_ptr;
    logic [THR_W-1:0]        ent_thr;
    logic [CNT_W-1:0]        sel_cnt;
    logic                    rule_ok;
    logic                    pass_all;
    logic                    used_any;

    // Capture the count vector when a pass is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= cnt_in;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_split
        assign cnt_arr[c] = cnt_q[c*CNT_W +: CNT_W];
    end

    // Select the pointed-to count and compare it with the threshold.
    always_comb begin
        ent_valid = rule[ENTRY_W-1];
        ent_ptr   = rule[THR_W +: PTR_W];
        ent_thr   = rule[THR_W-1:0];
        sel_cnt   = (int'(ent_ptr) < int'(NUM_CH)) ? cnt_arr[ent_ptr] : '0;
        rule_ok   = !ent_valid || (CMP_W'(sel_cnt) >= CMP_W'(ent_thr));
    end

    if (RULES_PER_STATE == 1) begin : g_single
        assign pass_all = rule_ok;
        assign used_any = ent_valid;
    end else begin : g_multi
        localparam int unsigned SR_W = RULES_PER_STATE - 1;
        logic [SR_W-1:0] pass_sr;
        logic [SR_W-1:0] used_sr;

        // Shift in each slot's result and valid flag as the pass steps.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pass_sr <= '0;
                used_sr <= '0;
            end else if (step) begin
                pass_sr <= SR_W'({pass_sr, rule_ok});
                used_sr <= SR_W'({used_sr, ent_valid});
            end
        end

        assign pass_all = &{pass_sr, rule_ok};
        assign used_any = |{used_sr, ent_valid};
    end

    // A state fires only if all slots pass and at least one is populated.
    always_comb begin
        state_bit = pass_all && used_any;
    end

endmodule

// File: rtl/sd_score_collect.sv
// Score collector: shifts each finished state bit into an accumulator so
// that state i ends at bit i, then publishes the full vector with a
// one-cycle valid pulse. The published vector holds until the next pass.
module sd_score_collect #(
    parameter int unsigned NUM_STATES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  state_done,
    input  logic                  pass_done,
    input  logic                  state_bit,
    output logic [NUM_STATES-1:0] score,
    output logic                  score_valid
);

    logic [NUM_STATES-1:0] collected;
    logic [NUM_STATES-1:0] score_q;
    logic                  valid_q;

    if (NUM_STATES == 1) begin : g_one
        assign collected = state_bit;
    end else begin : g_many
        logic [NUM_STATES-2:0] acc_q;

        assign collected = {state_bit, acc_q};

        // Slide earlier states toward bit 0 as each state completes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else if (state_done) begin
                acc_q <= collected[NUM_STATES-1:1];
            end
        end
    end

    // Publish the vector and raise valid for one cycle at pass end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            score_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= pass_done;
            if (pass_done) begin
                score_q <= collected;
            end
        end
    end

    assign score       = score_q;
    assign score_valid = valid_q;

endmodule

// File: rtl/sparse_rule_decoder.sv
// Top level of the sparse template rule decoder. Wires the sequencer,
// rule memory, evaluator and score collector together. The rule memory
// is locked for writes while a pass runs.
module sparse_rule_decoder
    import sd_pkg::*;
#(
    parameter int unsigned NUM_CH          = 32,
    parameter int unsigned CNT_W           = 4,
    parameter int unsigned NUM_STATES      = 8,
    parameter int unsigned RULES_PER_STATE = 2,
    localparam int unsigned PTR_W     = width_of(NUM_CH),
    localparam int unsigned ENTRY_W   = 1 + PTR_W + THR_W,
    localparam int unsigned NUM_RULES = NUM_STATES * RULES_PER_STATE,
    localparam int unsigned ADDR_W    = width_of(NUM_RULES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cnt_valid,
    input  logic [NUM_CH*CNT_W-1:0] cnt_vec,
    input  logic                    rule_wr_en,
    input  logic [ADDR_W-1:0]       rule_wr_addr,
    input  logic [ENTRY_W-1:0]      rule_wr_data,
    output logic                    busy,
    output logic                    overrun,
    output logic                    score_valid,
    output logic [NUM_STATES-1:0]   score
);

    localparam int unsigned STATE_W = width_of(NUM_STATES);
    localparam int unsigned SLOT_W  = width_of(RULES_PER_STATE);

    logic               accept;
    logic               slot_last;
    logic               state_last;
    logic [ADDR_W-1:0]  rd_addr;
    logic [ENTRY_W-1:0] rd_rule;
    logic               state_bit;
    logic               state_done;
    logic               pass_done;

    sd_sequencer #(
        .NUM_STATES     (NUM_STATES),
        .RULES_PER_STATE(RULES_PER_STATE),
        .STATE_W        (STATE_W),
        .SLOT_W         (SLOT_W),
        .ADDR_W         (ADDR_W)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (cnt_valid),
        .accept    (accept),
        .busy      (busy),
        .overrun   (overrun),
        .slot_last (slot_last),
        .state_last(state_last),
        .rule_addr (rd_addr)
    );

    sd_rule_mem #(
        .NUM_RULES(NUM_RULES),
        .ENTRY_W  (ENTRY_W),
        .ADDR_W   (ADDR_W)
    ) i_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (rule_wr_en),
        .wr_lock(busy),
        .wr_addr(rule_wr_addr),
        .wr_data(rule_wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_rule)
    );

    sd_rule_eval #(
        .NUM_CH         (NUM_CH),
        .CNT_W          (CNT_W),
        .RULES_PER_STATE(RULES_PER_STATE),
        .PTR_W          (PTR_W),
        .ENTRY_W        (ENTRY_W)
    ) i_eval (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .cnt_in   (cnt_vec),
        .step     (busy),
        .rule     (rd_rule),
        .state_bit(state_bit)
    );

    // Mark the last slot of each state and the last slot of the pass.
    always_comb begin
        state_done = busy && slot_last;
        pass_done  = busy && slot_last && state_last;
    end

    sd_score_collect #(
        .NUM_STATES(NUM_STATES)
    ) i_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_done (state_done),
        .pass_done  (pass_done),
        .state_bit  (state_bit),
        .score      (score),
        .score_valid(score_valid)
    );

endmodule

// File: rtl/sd_checker.sv
// Protocol checker for the sparse template rule decoder, bound to the top.
// Watches the strobe, busy, overrun and score ports and measures the
// pass length with a local counter.
module sd_checker #(
    parameter int unsigned NUM_STATES      = 8,
    parameter int unsigned RULES_PER_STATE = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cnt_valid,
    input logic                  busy,
    input logic                  overrun,
    input logic                  score_valid,
    input logic [NUM_STATES-1:0] score
);

    localparam int unsigned PASS_LEN = NUM_STATES * RULES_PER_STATE;

    logic [15:0] run_cnt;

    // Count busy cycles of the current pass; clear while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + 16'd1;
        end else begin
            run_cnt <= '0;
        end
    end

    assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        score_valid |=> !score_valid);

    assert_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        score_valid |-> (run_cnt == 16'(PASS_LEN)));

    assert_idle_at_score_R5: assert property (@(posedge clk) disable iff (!rst_n)
        score_valid |-> !busy);

    assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> score_valid);

    assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_valid && !busy) |=> busy);

    assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_valid && busy) |=> overrun);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !score_valid |-> $stable(score));

endmodule

bind sparse_rule_decoder sd_checker #(
    .NUM_STATES     (NUM_STATES),
    .RULES_PER_STATE(RULES_PER_STATE)
) i_sd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_valid  (cnt_valid),
    .busy       (busy),
    .overrun    (overrun),
    .score_valid(score_valid),
    .score      (score)
);

// File: tb/test_sparse_rule_decoder.sv
`timescale 1ns/1ps
// Self-checking bench: threshold/count sweep, AND and empty-slot cases,
// bit ordering, pseudo-random rule sets, overrun and write-lock cases.
module test_sparse_rule_decoder;

    localparam int NCH = 32;
    localparam int CW  = 4;
    localparam int M   = 8;
    localparam int K   = 2;
    localparam int NR  = M * K;
    localparam int EW  = 9;
    localparam int AW  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cnt_valid = 1'b0;
    logic [NCH*CW-1:0] cnt_vec = '0;
    logic            rule_wr_en = 1'b0;
    logic [AW-1:0]   rule_wr_addr = '0;
    logic [EW-1:0]   rule_wr_data = '0;
    logic            busy;
    logic            overrun;
    logic            score_valid;
    logic [M-1:0]    score;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [EW-1:0] model_rules [NR];

    always #4 clk = ~clk;

    sparse_rule_decoder #(
        .NUM_CH(NCH), .CNT_W(CW), .NUM_STATES(M), .RULES_PER_STATE(K)
    ) i_sparse_rule_decoder (
        .clk(clk), .rst_n(rst_n), .cnt_valid(cnt_valid), .cnt_vec(cnt_vec),
        .rule_wr_en(rule_wr_en), .rule_wr_addr(rule_wr_addr),
        .rule_wr_data(rule_wr_data), .busy(busy), .overrun(overrun),
        .score_valid(score_valid), .score(score)
    );

    function automatic logic [M-1:0] model_score(input logic [NCH*CW-1:0] v);
        logic [M-1:0] r;
        r = '0;
        for (int s = 0; s < M; s++) begin
            bit all_ok = 1'b1;
            bit any = 1'b0;
            for (int k = 0; k < K; k++) begin
                logic [EW-1:0] e = model_rules[s*K+k];
                if (e[8]) begin
                    int ch = int'(e[7:3]);
                    any = 1'b1;
                    if (int'(v[ch*CW +: CW]) < int'(e[2:0])) all_ok = 1'b0;
                end
            end
            r[s] = all_ok & any;
        end
        return r;
    endfunction

    function automatic logic [NCH*CW-1:0] set_cnt(input logic [NCH*CW-1:0] v,
                                                  input int ch, input int val);
        logic [NCH*CW-1:0] r = v;
        r[ch*CW +: CW] = CW'(val);
        return r;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_rule(input int addr, input bit v, input int ptr, input int thr);
        rule_wr_en   = 1'b1;
        rule_wr_addr = AW'(addr);
        rule_wr_data = {v, 5'(ptr), 3'(thr)};
        @(negedge clk);
        rule_wr_en   = 1'b0;
        model_rules[addr] = {v, 5'(ptr), 3'(thr)};
    endtask

    task automatic clear_rules();
        for (int a = 0; a < NR; a++) put_rule(a, 1'b0, 0, 0);
    endtask

    task automatic decode(input logic [NCH*CW-1:0] v, input string req,
                          output logic [M-1:0] got);
        logic [M-1:0] exp;
        int n;
        exp = model_score(v);
        cnt_vec   = v;
        cnt_valid = 1'b1;
        @(negedge clk);
        cnt_valid = 1'b0;
        n = 0;
        while (!score_valid && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(n == NR, "R5 latency", n, NR);
        check(!busy, "R5 busy low at score", 32'(busy), 0);
        check(score == exp, req, 32'(score), 32'(exp));
        got = score;
        @(negedge clk);
        check(!score_valid, "R5 pulse width", 32'(score_valid), 0);
    endtask

    initial begin
        logic [M-1:0] got;
        logic [NCH*CW-1:0] v;
        for (int a = 0; a < NR; a++) model_rules[a] = '0;

        // R8: reset state
        repeat (3) @(negedge clk);
        check(score == '0, "R8 score", 32'(score), 0);
        check(!score_valid, "R8 score_valid", 32'(score_valid), 0);
        check(!busy, "R8 busy", 32'(busy), 0);
        check(!overrun, "R8 overrun", 32'(overrun), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 / R3: all entries invalid after reset -> all states score 0
        decode({NCH*CW{1'b1}}, "R8 empty rules", got);
        check(got == '0, "R3 all-invalid state scores 0", 32'(got), 0);

        // R1: every threshold against every count, empty second slot (R3)
        for (int t = 1; t <= 7; t++) begin
            for (int c = 0; c < 16; c++) begin
                int ch = (t * 5 + c) % NCH;
                put_rule(3*K + 0, 1'b1, ch, t);
                v = '1;
                v = set_cnt(v, ch, c);
                decode(v, "R1 threshold sweep", got);
                check(got == M'((c >= t) ? (1 << 3) : 0), "R1 explicit",
                      32'(got), (c >= t) ? 8 : 0);
            end
        end

        // R2: two valid rules combined with AND
        clear_rules();
        put_rule(5*K + 0, 1'b1, 2, 4);
        put_rule(5*K + 1, 1'b1, 9, 2);
        for (int ai = 0; ai < 3; ai++) begin
            for (int bi = 0; bi < 3; bi++) begin
                int a = (ai == 0) ? 3 : (ai == 1) ? 4 : 15;
                int b = (bi == 0) ? 0 : (bi == 1) ? 2 : 7;
                bit fire = (a >= 4) && (b >= 2);
                v = '0;
                v = set_cnt(v, 2, a);
                v = set_cnt(v, 9, b);
                decode(v, "R2 and", got);
                check(got == M'(fire ? (1 << 5) : 0), "R2 explicit",
                      32'(got), fire ? 32 : 0);
            end
        end

        // R3: empty first slot does not block the state
        clear_rules();
        put_rule(6*K + 1, 1'b1, 20, 3);
        v = set_cnt('0, 20, 3);
        decode(v, "R3 empty slot", got);
        check(got == M'(1 << 6), "R3 empty slot fires", 32'(got), 64);
        v = set_cnt('0, 20, 2);
        decode(v, "R3 empty slot", got);
        check(got == '0, "R3 below threshold", 32'(got), 0);

        // R4: bit i belongs to state i
        for (int i = 0; i < M; i++) begin
            clear_rules();
            put_rule(i*K + 1, 1'b1, i + 10, 1);
            v = set_cnt('0, i + 10, 1);
            decode(v, "R4 ordering", got);
            check(got == M'(1 << i), "R4 explicit", 32'(got), 32'(1 << i));
        end

        // R2 / R4: pseudo-random rule sets and count vectors
        for (int it = 0; it < 60; it++) begin
            for (int a = 0; a < NR; a++)
                put_rule(a, $urandom_range(0, 3) != 0, $urandom_range(0, NCH-1),
                         $urandom_range(1, 7));
            v = '0;
            for (int c = 0; c < NCH; c++) v = set_cnt(v, c, $urandom_range(0, 9));
            decode(v, "R2 random", got);
        end

        // R6: strobe mid-pass is flagged and dropped
        begin
            logic [NCH*CW-1:0] va, vb;
            logic [M-1:0] expa;
            int n, pulses;
            clear_rules();
            put_rule(1*K + 0, 1'b1, 4, 5);
            va = set_cnt('0, 4, 6);
            vb = '0;
            expa = model_score(va);
            cnt_vec = va;
            cnt_valid = 1'b1;
            @(negedge clk);
            cnt_vec = vb;
            @(negedge clk);
            cnt_valid = 1'b0;
            check(overrun == 1'b1, "R6 overrun flagged", 32'(overrun), 1);
            @(negedge clk);
            check(overrun == 1'b0, "R6 overrun one cycle", 32'(overrun), 0);
            n = 0;
            while (!score_valid && n < 1000) begin
                @(negedge clk);
                n++;
            end
            check(score == expa, "R6 first vector kept", 32'(score), 32'(expa));
            pulses = 0;
            repeat (3 * NR) begin
                @(negedge clk);
                if (score_valid) pulses++;
            end
            check(pulses == 0, "R6 dropped strobe no score", pulses, 0);
        end

        // R7: write during a pass is ignored; idle write takes effect
        begin
            int n;
            clear_rules();
            put_rule(0, 1'b1, 1, 1);
            v = set_cnt('0, 1, 5);
            cnt_vec = v;
            cnt_valid = 1'b1;
            @(negedge clk);
            cnt_valid = 1'b0;
            rule_wr_en = 1'b1;
            rule_wr_addr = '0;
            rule_wr_data = {1'b1, 5'd1, 3'd7};
            @(negedge clk);
            rule_wr_en = 1'b0;
            n = 0;
            while (!score_valid && n < 1000) begin
                @(negedge clk);
                n++;
            end
            check(score == M'(1), "R7 current pass", 32'(score), 1);
            @(negedge clk);
            decode(v, "R7 busy write ignored", got);
            check(got == M'(1), "R7 explicit ignored", 32'(got), 1);
            put_rule(0, 1'b1, 1, 7);
            decode(v, "R7 idle write used", got);
            check(got == '0, "R7 explicit used", 32'(got), 0);
        end

        // R9: score holds between pulses
        begin
            bit held = 1'b1;
            put_rule(0, 1'b1, 1, 2);
            decode(v, "R9 setup", got);
            repeat (6) begin
                @(negedge clk);
                if (score !== got) held = 1'b0;
            end
            check(held, "R9 score held", 32'(score), 32'(got));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule